// File: doc/BRIEF.md
# Z80 I/O Cycle Wait Stretcher

This block sits beside a Z80 bus and holds the CPU in wait states whenever an I/O read, an I/O write or an interrupt acknowledge begins. It brings the four active-low CPU strobes into a local clock domain through a configurable synchronizer chain. It then classifies the cycle and finds the rising edge of a request. That edge sets a latch whose output pulls WAIT low. The CPU stays frozen until a local controller, which may be much slower than a real peripheral, has done its work and sends a single-cycle clear pulse.

While the latch is set, the controller can poll a busy flag and three cycle-type bits. The type bits are captured at the moment the latch sets. After a clear, the block will not accept another cycle until IORQ has been seen high again. This stops the tail end of the serviced cycle from triggering a second stretch.

Top module: `io_wait_stretch`

## Requirements
- R1: After reset, wait_n_o is 1, and busy_o, type_rd_o, type_wr_o and type_ack_o are all 0.
- R2: An I/O read (iorq_n_i=0, rd_n_i=0) sets busy_o=1, drives wait_n_o=0 and sets type_rd_o=1.
- R3: An I/O write (iorq_n_i=0, wr_n_i=0, rd_n_i=1) sets busy_o=1, drives wait_n_o=0 and sets type_wr_o=1.
- R4: An interrupt acknowledge (iorq_n_i=0, m1_n_i=0, rd_n_i=1, wr_n_i=1) sets busy_o=1, drives wait_n_o=0 and sets type_ack_o=1.
- R5: No stretch starts while iorq_n_i=1, whatever the other strobes do. None starts either when iorq_n_i=0 with rd_n_i, wr_n_i and m1_n_i all 1.
- R6: Let edge 1 be the first clk rising edge that samples a request. wait_n_o falls after edge SYNC_STAGES+1 and is still 1 after edge SYNC_STAGES.
- R7: Once set, busy_o stays 1 and wait_n_o stays 0 for any number of cycles until clr_i is seen high.
- R8: clr_i high at a rising edge releases the block after that edge: wait_n_o=1, busy_o=0 and all type bits 0.
- R9: If a new setting edge and clr_i fall on the same clock edge, the set wins, and busy_o is 1 after that edge.
- R10: After a cycle has set the latch, no further request edge can set it again until the synchronized iorq_n_i has been 1.
- R11: At most one type bit is 1 at any time, and the type bits do not change while the latch stays set. Precedence is read over write over acknowledge, so a cycle with rd_n_i=0 and m1_n_i=0 reports read and one with wr_n_i=0 and m1_n_i=0 reports write.
- R12: rst_ni=0 releases wait_n_o to 1 at once (asynchronously), even in the middle of a stretched cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| iorq_n_i | input | 1 | CPU I/O request strobe, active low, asynchronous |
| rd_n_i | input | 1 | CPU read strobe, active low, asynchronous |
| wr_n_i | input | 1 | CPU write strobe, active low, asynchronous |
| m1_n_i | input | 1 | CPU opcode-fetch/acknowledge strobe, active low, asynchronous |
| clr_i | input | 1 | Single-cycle release pulse from the controller |
| wait_n_o | output | 1 | WAIT to the CPU, active low |
| busy_o | output | 1 | A stretched cycle is in progress |
| type_rd_o | output | 1 | Captured cycle was an I/O read |
| type_wr_o | output | 1 | Captured cycle was an I/O write |
| type_ack_o | output | 1 | Captured cycle was an interrupt acknowledge |

## Verification
The two functions that can land on one clock edge are the controller's release pulse and the setting edge of a new request. The bench provokes this by raising clr_i in exactly the cycle in which the synchronized request first shows its rising edge. It then judges the result by requiring busy_o=1 and wait_n_o=0 after that edge and for several cycles beyond it. A second case holds IORQ low across a release while RD and WR toggle, and checks that the re-armed edge is ignored.

// File: rtl/io_wait_stretch_pkg.sv
package io_wait_stretch_pkg;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_READ  = 2'd1,
      KIND_WRITE = 2'd2,
      KIND_ACK   = 2'd3
   } cyc_kind_e;

   typedef struct packed {
      logic iorq_n;
      logic rd_n;
      logic wr_n;
      logic m1_n;
   } strobes_t;

   localparam int unsigned STROBE_W = $bits(strobes_t);

endpackage

// File: rtl/iows_sync.sv
module iows_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned WIDTH   = 4,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int unsigned LAST = STAGES - 1;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;

      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= RST_VAL;
            else         chain_q <= async_i[b];
         end
      end else begin : g_many
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
            else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
         end
      end

      assign sync_o[b] = chain_q[LAST];
   end

endmodule

// File: rtl/iows_decode.sv
module iows_decode
   import io_wait_stretch_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  strobes_t  strb_i,
   output cyc_kind_e kind_o,
   output logic      start_o,
   output logic      iorq_idle_o
);

   cyc_kind_e kind_w;
   logic      req_w;
   logic      req_q;

   always_comb begin
      kind_w = KIND_NONE;
      if (!strb_i.iorq_n) begin
         if (!strb_i.rd_n)      kind_w = KIND_READ;
         else if (!strb_i.wr_n) kind_w = KIND_WRITE;
         else if (!strb_i.m1_n) kind_w = KIND_ACK;
      end
   end

   assign req_w = (kind_w != KIND_NONE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= 1'b0;
      else         req_q <= req_w;
   end

   assign start_o     = req_w & ~req_q;
   assign kind_o      = kind_w;
   assign iorq_idle_o = strb_i.iorq_n;

endmodule

// File: rtl/iows_latch.sv
module iows_latch
   import io_wait_stretch_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      start_i,
   input  cyc_kind_e kind_i,
   input  logic      iorq_idle_i,
   input  logic      clr_i,
   output logic      set_o,
   output logic      armed_o,
   output logic      busy_o,
   output cyc_kind_e kind_o
);

   logic      armed_q;
   logic      busy_q;
   cyc_kind_e kind_q;
   logic      set_w;

   assign set_w = start_i & armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q  <= 1'b0;
         armed_q <= 1'b1;
         kind_q  <= KIND_NONE;
      end else begin
         busy_q <= set_w | (busy_q & ~clr_i);
         if (set_w)            armed_q <= 1'b0;
         else if (iorq_idle_i) armed_q <= 1'b1;
         if (set_w)      kind_q <= kind_i;
         else if (clr_i) kind_q <= KIND_NONE;
      end
   end

   assign set_o   = set_w;
   assign armed_o = armed_q;
   assign busy_o  = busy_q;
   assign kind_o  = kind_q;

endmodule

// File: rtl/io_wait_stretch.sv
module io_wait_stretch
   import io_wait_stretch_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic iorq_n_i,
   input  logic rd_n_i,
   input  logic wr_n_i,
   input  logic m1_n_i,
   input  logic clr_i,
   output logic wait_n_o,
   output logic busy_o,
   output logic type_rd_o,
   output logic type_wr_o,
   output logic type_ack_o
);

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_stages
      $error("io_wait_stretch: SYNC_STAGES must be 1 to 4");
   end

   strobes_t  raw_w;
   strobes_t  sync_w;
   cyc_kind_e dec_kind_w;
   cyc_kind_e held_kind_w;
   logic      start_w;
   logic      iorq_idle_w;
   logic      set_w;
   logic      armed_w;
   logic      busy_w;

   assign raw_w = '{iorq_n: iorq_n_i, rd_n: rd_n_i, wr_n: wr_n_i, m1_n: m1_n_i};

   iows_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (STROBE_W),
      .RST_VAL(1'b1)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw_w),
      .sync_o (sync_w)
   );

   iows_decode decode_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .strb_i     (sync_w),
      .kind_o     (dec_kind_w),
      .start_o    (start_w),
      .iorq_idle_o(iorq_idle_w)
   );

   iows_latch latch_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_w),
      .kind_i     (dec_kind_w),
      .iorq_idle_i(iorq_idle_w),
      .clr_i      (clr_i),
      .set_o      (set_w),
      .armed_o    (armed_w),
      .busy_o     (busy_w),
      .kind_o     (held_kind_w)
   );

   assign wait_n_o   = ~busy_w;
   assign busy_o     = busy_w;
   assign type_rd_o  = (held_kind_w == KIND_READ);
   assign type_wr_o  = (held_kind_w == KIND_WRITE);
   assign type_ack_o = (held_kind_w == KIND_ACK);

endmodule

// File: rtl/io_wait_stretch_chk.sv
module io_wait_stretch_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic clr_i,
   input logic set_w,
   input logic armed_w,
   input logic iorq_idle_w,
   input logic wait_n_o,
   input logic busy_o,
   input logic type_rd_o,
   input logic type_wr_o,
   input logic type_ack_o
);

   // R7
   hold_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !clr_i |=> busy_o && !wait_n_o);

   // R8
   release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && !set_w |=> wait_n_o && !type_rd_o && !type_wr_o && !type_ack_o);

   // R9
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_w && clr_i |=> busy_o && !wait_n_o);

   // R10
   rearm_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_w && !iorq_idle_w && !set_w |=> !armed_w);

   // R11
   type_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({type_rd_o, type_wr_o, type_ack_o}));

   // R11
   type_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !clr_i && !set_w |=> $stable({type_rd_o, type_wr_o, type_ack_o}));

   // R11
   type_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !type_rd_o && !type_wr_o && !type_ack_o);

endmodule

bind io_wait_stretch io_wait_stretch_chk chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .clr_i      (clr_i),
   .set_w      (set_w),
   .armed_w    (armed_w),
   .iorq_idle_w(iorq_idle_w),
   .wait_n_o   (wait_n_o),
   .busy_o     (busy_o),
   .type_rd_o  (type_rd_o),
   .type_wr_o  (type_wr_o),
   .type_ack_o (type_ack_o)
);

// File: tb/io_wait_stretch_tb_top.sv
module io_wait_stretch_tb_top;

   localparam int unsigned SS = 2;
   localparam int unsigned NVEC = 8;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
   logic clr = 1'b0;
   logic wait_n, busy, t_rd, t_wr, t_ack;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   io_wait_stretch #(.SYNC_STAGES(SS)) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_ni),
      .iorq_n_i  (iorq_n),
      .rd_n_i    (rd_n),
      .wr_n_i    (wr_n),
      .m1_n_i    (m1_n),
      .clr_i     (clr),
      .wait_n_o  (wait_n),
      .busy_o    (busy),
      .type_rd_o (t_rd),
      .type_wr_o (t_wr),
      .type_ack_o(t_ack)
   );

   // stimulus {iorq_n, rd_n, wr_n, m1_n}, expected {wait_n, busy, rd, wr, ack}
   localparam logic [8:0] VEC [NVEC] = '{
      {4'b0011, 5'b01100},   // R2 read
      {4'b0101, 5'b01010},   // R3 write
      {4'b0110, 5'b01001},   // R4 acknowledge
      {4'b1011, 5'b10000},   // R5 no IORQ
      {4'b1100, 5'b10000},   // R5 no IORQ
      {4'b0111, 5'b10000},   // R5 IORQ alone
      {4'b0010, 5'b01100},   // R11 read over M1
      {4'b0100, 5'b01010}    // R11 write over M1
   };

   localparam logic [4:0] IDLE_OUT = 5'b10000;

   function automatic logic [4:0] outs();
      return {wait_n, busy, t_rd, t_wr, t_ack};
   endfunction

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle();
      iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_clr();
      clr = 1'b1;
      cyc(1);
      clr = 1'b0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      chk("R1", outs(), IDLE_OUT);
      rst_ni = 1'b1;
      cyc(2);
      chk("R1", outs(), IDLE_OUT);

      for (int v = 0; v < NVEC; v++) begin
         {iorq_n, rd_n, wr_n, m1_n} = VEC[v][8:5];
         cyc(SS);
         chk("R6", outs(), IDLE_OUT);
         cyc(1);
         chk($sformatf("R2/R3/R4/R5/R11 vec%0d", v), outs(), VEC[v][4:0]);
         if (VEC[v][3]) begin
            cyc(20);
            chk("R7", outs(), VEC[v][4:0]);
         end
         pulse_clr();
         chk("R8", outs(), IDLE_OUT);
         idle();
         cyc(SS + 3);
         chk("R8", outs(), IDLE_OUT);
      end

      // R10: IORQ held low across a release, RD then WR toggled
      iorq_n = 1'b0; rd_n = 1'b0;
      cyc(SS + 1);
      chk("R10", outs(), 5'b01100);
      pulse_clr();
      rd_n = 1'b1;
      cyc(SS + 3);
      wr_n = 1'b0;
      cyc(SS + 3);
      chk("R10", outs(), IDLE_OUT);
      iorq_n = 1'b1; wr_n = 1'b1;
      cyc(SS + 3);
      iorq_n = 1'b0; wr_n = 1'b0;
      cyc(SS + 1);
      chk("R10", outs(), 5'b01010);
      pulse_clr();
      idle();
      cyc(SS + 3);

      // R9: release pulse on the same edge as a new setting edge
      iorq_n = 1'b0; m1_n = 1'b0;
      cyc(SS);
      clr = 1'b1;
      cyc(1);
      clr = 1'b0;
      chk("R9", outs(), 5'b01001);
      cyc(5);
      chk("R9", outs(), 5'b01001);
      pulse_clr();
      idle();
      cyc(SS + 3);

      // R12: reset in the middle of a stretched cycle
      iorq_n = 1'b0; rd_n = 1'b0;
      cyc(SS + 1);
      chk("R12", outs(), 5'b01100);
      rst_ni = 1'b0;
      #1;
      chk("R12", outs(), IDLE_OUT);
      idle();
      cyc(2);
      rst_ni = 1'b1;
      cyc(SS + 3);
      chk("R12", outs(), IDLE_OUT);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule